// File: doc/BRIEF.md
# Flash Region Protection and Commit Controller

This block sits between the flash access path and the flash array. It decides, one region at a time, which accesses are allowed. It keeps two permission vectors with one bit per protected region. The read vector allows reads and instruction fetches. The erase/program vector allows programming and erasing. Each vector exists twice: a working copy that screens every access, and a committed copy that stands in for the non-volatile setting. Every read, program, page-erase or mass-erase request is checked in the same cycle against the working copy. A refused read returns a zero data word. A refused program or erase is not granted, so the flash array is never touched. A refused request of any kind sets a sticky violation flag, which can drive an interrupt.

Software can only clear protection bits in the working copy, and the change takes effect at once so that it can be tried out. To make the change permanent, software writes a target select into the address register and then sets the commit bit in the control register. A fixed multi-cycle commit sequence then copies the chosen working vector into its committed copy. A power-on reset reloads both working vectors from the committed copies, which throws away any change that was not committed. A separate factory-initialisation reset sets the committed copies to all ones, which means no protection at all.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After factory initialisation and power-on reset, the read-enable register (offset 2) and the program-enable register (offset 3) read all ones in their NUM_BLK low bits. The status register (offset 4) and the mask register (offset 5) read 0, and `irq` is 0.
- R2: The region of a request is the top log2(NUM_BLK) bits of `acc_addr`. A read (`acc_op`=0) to a region whose working read bit is 0 is refused in the same cycle: `acc_grant`=0 and `acc_rdata`=0. A granted read returns `flash_rdata` unchanged.
- R3: A program (`acc_op`=1) or a page erase (`acc_op`=2) is granted in the same cycle exactly when the working program-enable bit of the addressed region is 1. A region with read bit 1 and program bit 0 is therefore read-only.
- R4: A mass erase (`acc_op`=3) is granted only when every working program-enable bit is 1. Otherwise the whole request is refused.
- R5: A refused request sets status bit 0 at the next clock edge. The bit stays set until 1 is written to status bit 0. `irq` is status bit 0 ANDed with mask bit 0.
- R6: A write to the read-enable or program-enable register can only clear bits. The new working value is the old value ANDed with the written data, so writing 1 over a 0 has no effect.
- R7: Writing 1 to control bit 0 (offset 1) while no commit is running starts a commit. Control bit 0 reads 1 for exactly COMMIT_CYCLES cycles. At the end, the working vector chosen by address-register bit 0 (offset 0) is copied into its committed copy: 1 selects program-enable, 0 selects read-enable.
- R8: A power-on reset (`rst_n` low) reloads both working vectors from their committed copies. Cleared bits that were committed stay 0, and cleared bits that were not committed return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| nvm_init_n | input | 1 | Synchronous active-low factory initialisation of the committed copies |
| reg_sel | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| acc_valid | input | 1 | Access request valid |
| acc_op | input | 2 | 0 read, 1 program, 2 page erase, 3 mass erase |
| acc_addr | input | ADDR_W | Byte address of the request |
| flash_rdata | input | DATA_W | Data word from the array for a read |
| acc_grant | output | 1 | Request is allowed |
| acc_rdata | output | DATA_W | Screened read data |
| irq | output | 1 | Access-violation interrupt |

## Verification
The hardest situation to reach from the ports is a power-on reset that follows a mix of committed and uncommitted clears on both vectors. Only then do committed and working copies differ in a way that R8 can expose. The stimulus clears random single bits, commits one vector picked at random, clears further bits, and then pulses `rst_n`. The bench model predicts which bits come back. Each commit is also timed cycle by cycle against the busy readback.

// File: rtl/flash_prot_pkg.sv
// Package: shared encodings for the flash protection controller.
// Assumes a register interface with at most 8 offsets.
package flash_prot_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_PROG   = 2'd1,
        OP_PERASE = 2'd2,
        OP_MERASE = 2'd3
    } fp_op_e;

    localparam logic [2:0] REG_ADDR = 3'd0;
    localparam logic [2:0] REG_CTRL = 3'd1;
    localparam logic [2:0] REG_RDEN = 3'd2;
    localparam logic [2:0] REG_PEEN = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;
    localparam logic [2:0] REG_MASK = 3'd5;

endpackage

// File: rtl/fp_nv_store.sv
// Module: fp_nv_store
// Holds the committed (non-volatile) copies of both permission vectors
// and runs the fixed-length commit sequence.
// Assumes: nvm_init_n is asserted only for factory initialisation.
// rst_n aborts a running commit but never touches the committed copies.
module fp_nv_store #(
    parameter int NUM_BLK       = 8,
    parameter int COMMIT_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nvm_init_n,
    input  logic               commit_req,
    input  logic               commit_sel,
    input  logic [NUM_BLK-1:0] rd_work,
    input  logic [NUM_BLK-1:0] pe_work,
    output logic [NUM_BLK-1:0] rd_nv,
    output logic [NUM_BLK-1:0] pe_nv,
    output logic               busy,
    output logic               commit_tgt
);
    localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             commit_done;

    assign commit_done = busy && (cnt == '0);

    // Commit sequencer: start on request when idle, count down, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt        <= '0;
            commit_tgt <= 1'b0;
        end else if (commit_req && !busy) begin
            busy       <= 1'b1;
            cnt        <= CNT_W'(COMMIT_CYCLES - 1);
            commit_tgt <= commit_sel;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Committed copies: factory default all ones, updated at commit end.
    always_ff @(posedge clk) begin
        if (!nvm_init_n) begin
            rd_nv <= '1;
            pe_nv <= '1;
        end else if (commit_done) begin
            if (commit_tgt) begin
                pe_nv <= pe_work;
            end else begin
                rd_nv <= rd_work;
            end
        end
    end

endmodule

// File: rtl/fp_regs.sv
// Module: fp_regs
// Register file: address, control, working permission vectors,
// violation status and interrupt mask.
// Assumes NUM_BLK <= 32. The working vectors can only be cleared by
// software and are reloaded from the committed copies on rst_n.
module fp_regs
    import flash_prot_pkg::*;
#(
    parameter int NUM_BLK = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         reg_sel,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_BLK-1:0] rd_nv,
    input  logic [NUM_BLK-1:0] pe_nv,
    input  logic               busy,
    input  logic               viol_evt,
    output logic [NUM_BLK-1:0] rd_work,
    output logic [NUM_BLK-1:0] pe_work,
    output logic               commit_req,
    output logic               commit_sel,
    output logic               viol,
    output logic               irq_en
);
    logic [31:0] addr_q;
    logic        wr_addr, wr_rden, wr_peen, wr_stat, wr_mask;

    // Decode write strobes per register.
    always_comb begin
        wr_addr    = reg_we && (reg_sel == REG_ADDR);
        wr_rden    = reg_we && (reg_sel == REG_RDEN);
        wr_peen    = reg_we && (reg_sel == REG_PEEN);
        wr_stat    = reg_we && (reg_sel == REG_STAT);
        wr_mask    = reg_we && (reg_sel == REG_MASK);
        commit_req = reg_we && (reg_sel == REG_CTRL) && reg_wdata[0];
    end

    assign commit_sel = addr_q[0];

    // Address and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            irq_en <= 1'b0;
        end else begin
            if (wr_addr) addr_q <= reg_wdata;
            if (wr_mask) irq_en <= reg_wdata[0];
        end
    end

    // Working vectors: reload on power-on reset, clear-only writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_work <= rd_nv;
            pe_work <= pe_nv;
        end else begin
            if (wr_rden) rd_work <= rd_work & reg_wdata[NUM_BLK-1:0];
            if (wr_peen) pe_work <= pe_work & reg_wdata[NUM_BLK-1:0];
        end
    end

    // Sticky violation flag; a new violation wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol <= 1'b0;
        end else if (viol_evt) begin
            viol <= 1'b1;
        end else if (wr_stat && reg_wdata[0]) begin
            viol <= 1'b0;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (reg_sel)
            REG_ADDR: reg_rdata = addr_q;
            REG_CTRL: reg_rdata = {31'd0, busy};
            REG_RDEN: reg_rdata = 32'(rd_work);
            REG_PEEN: reg_rdata = 32'(pe_work);
            REG_STAT: reg_rdata = {31'd0, viol};
            REG_MASK: reg_rdata = {31'd0, irq_en};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fp_access_check.sv
// Module: fp_access_check
// Screens one access per cycle against the working permission vectors.
// Assumes the array holds NUM_BLK regions of PAGES_PER_BLK pages each,
// both powers of two, and that read data arrives with the request.
module fp_access_check
    import flash_prot_pkg::*;
#(
    parameter int NUM_BLK = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 32
) (
    input  logic               acc_valid,
    input  logic [1:0]         acc_op,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  flash_rdata,
    input  logic [NUM_BLK-1:0] rd_work,
    input  logic [NUM_BLK-1:0] pe_work,
    output logic               acc_grant,
    output logic [DATA_W-1:0]  acc_rdata,
    output logic               viol_evt
);
    localparam int BLK_W = $clog2(NUM_BLK);

    logic [BLK_W-1:0]   blk_idx;
    logic [NUM_BLK-1:0] blk_hit;
    logic               rd_ok, pe_ok, all_pe_ok;
    fp_op_e             op;

    assign op      = fp_op_e'(acc_op);
    assign blk_idx = BLK_W'(acc_addr >> (ADDR_W - BLK_W));

    // One-hot region decode.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_hit
        assign blk_hit[g] = (blk_idx == BLK_W'(g));
    end

    assign rd_ok     = |(blk_hit & rd_work);
    assign pe_ok     = |(blk_hit & pe_work);
    assign all_pe_ok = &pe_work;

    // Permission decision per operation.
    always_comb begin
        case (op)
            OP_READ:   acc_grant = acc_valid && rd_ok;
            OP_PROG,
            OP_PERASE: acc_grant = acc_valid && pe_ok;
            default:   acc_grant = acc_valid && all_pe_ok;
        endcase
    end

    assign viol_evt  = acc_valid && !acc_grant;
    assign acc_rdata = (acc_grant && op == OP_READ) ? flash_rdata : '0;

endmodule

// File: rtl/flash_prot_ctrl.sv
// Module: flash_prot_ctrl (top)
// Per-region read and program/erase protection with a software commit.
// Assumes: ADDR_W covers exactly NUM_BLK*PAGES_PER_BLK pages of
// PAGE_BYTES bytes; nvm_init_n is pulsed once at factory setup.
module flash_prot_ctrl #(
    parameter int NUM_BLK       = 8,
    parameter int PAGES_PER_BLK = 2,
    parameter int PAGE_BYTES    = 1024,
    parameter int DATA_W        = 32,
    parameter int COMMIT_CYCLES = 4,
    parameter int ADDR_W        = $clog2(NUM_BLK) + $clog2(PAGES_PER_BLK) + $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nvm_init_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic              acc_grant,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              irq
);
    logic [NUM_BLK-1:0] rd_work, pe_work, rd_nv, pe_nv;
    logic               busy, commit_tgt, commit_req, commit_sel;
    logic               viol, irq_en, viol_evt;

    fp_nv_store #(.NUM_BLK(NUM_BLK), .COMMIT_CYCLES(COMMIT_CYCLES)) u_nv (
        .clk(clk), .rst_n(rst_n), .nvm_init_n(nvm_init_n),
        .commit_req(commit_req), .commit_sel(commit_sel),
        .rd_work(rd_work), .pe_work(pe_work),
        .rd_nv(rd_nv), .pe_nv(pe_nv),
        .busy(busy), .commit_tgt(commit_tgt)
    );

    fp_regs #(.NUM_BLK(NUM_BLK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_nv(rd_nv), .pe_nv(pe_nv), .busy(busy), .viol_evt(viol_evt),
        .rd_work(rd_work), .pe_work(pe_work),
        .commit_req(commit_req), .commit_sel(commit_sel),
        .viol(viol), .irq_en(irq_en)
    );

    fp_access_check #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk_path (
        .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr),
        .flash_rdata(flash_rdata), .rd_work(rd_work), .pe_work(pe_work),
        .acc_grant(acc_grant), .acc_rdata(acc_rdata), .viol_evt(viol_evt)
    );

    // Interrupt output: sticky violation gated by the mask.
    assign irq = viol & irq_en;

endmodule

// File: rtl/flash_prot_ctrl_chk.sv
// Module: flash_prot_ctrl_chk
// Assertion checker bound into flash_prot_ctrl.
module flash_prot_ctrl_chk #(
    parameter int NUM_BLK = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               nvm_init_n,
    input logic               acc_valid,
    input logic [1:0]         acc_op,
    input logic               acc_grant,
    input logic [DATA_W-1:0]  acc_rdata,
    input logic               irq,
    input logic               irq_en,
    input logic               viol,
    input logic               busy,
    input logic               commit_tgt,
    input logic [NUM_BLK-1:0] rd_work,
    input logic [NUM_BLK-1:0] pe_work,
    input logic [NUM_BLK-1:0] rd_nv,
    input logic [NUM_BLK-1:0] pe_nv
);
    // R2: a refused read never leaks data.
    assert_rd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 2'd0 && !acc_grant) |-> (acc_rdata == '0));

    // R4: mass erase refused while any region is write-protected.
    assert_mass_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 2'd3 && !(&pe_work)) |-> !acc_grant);

    // R5: a refused request leaves the violation flag set.
    assert_viol_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_grant) |=> viol);

    // R5: no interrupt while masked.
    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R6: working bits never rise outside reset.
    assert_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((rd_work & ~$past(rd_work)) == '0) &&
                          ((pe_work & ~$past(pe_work)) == '0)));

    // R7: at commit end the selected committed copy takes the working value.
    assert_commit_copy_R7: assert property (@(posedge clk) disable iff (!rst_n || !nvm_init_n)
        ($past(rst_n) && $fell(busy)) |->
            ((commit_tgt ? pe_nv : rd_nv) == $past(commit_tgt ? pe_work : rd_work)));

endmodule

bind flash_prot_ctrl flash_prot_ctrl_chk #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_prot_chk (
    .clk(clk), .rst_n(rst_n), .nvm_init_n(nvm_init_n),
    .acc_valid(acc_valid), .acc_op(acc_op), .acc_grant(acc_grant),
    .acc_rdata(acc_rdata), .irq(irq), .irq_en(irq_en), .viol(viol),
    .busy(busy), .commit_tgt(commit_tgt),
    .rd_work(rd_work), .pe_work(pe_work), .rd_nv(rd_nv), .pe_nv(pe_nv)
);

// File: tb/tb_flash_prot_ctrl.sv
// Bench for flash_prot_ctrl: random stimulus with a fixed seed plus
// directed corners, checked against a bench-side model.
module tb_flash_prot_ctrl;
    localparam int NB  = 8;
    localparam int DW  = 32;
    localparam int CC  = 4;
    localparam int AW  = 14;
    localparam int BLK_SHIFT = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, nvm_init_n = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0, reg_rdata;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_op = '0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] flash_rdata = '0, acc_rdata;
    logic          acc_grant, irq;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    // Model state
    logic [NB-1:0] m_rd, m_pe, m_rd_nv, m_pe_nv;
    logic          m_viol, m_mask, m_sel;

    always #5 clk = ~clk;

    flash_prot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .nvm_init_n(nvm_init_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr),
        .flash_rdata(flash_rdata), .acc_grant(acc_grant), .acc_rdata(acc_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_grant(input logic [1:0] op, input logic [AW-1:0] a,
                                     input logic [NB-1:0] rd, input logic [NB-1:0] pe);
        int b = int'(a >> BLK_SHIFT);
        case (op)
            2'd0:    return rd[b];
            2'd1:    return pe[b];
            2'd2:    return pe[b];
            default: return &pe;
        endcase
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            3'd0: m_sel = d[0];
            3'd2: m_rd = m_rd & d[NB-1:0];
            3'd3: m_pe = m_pe & d[NB-1:0];
            3'd4: if (d[0]) m_viol = 1'b0;
            3'd5: m_mask = d[0];
            default: ;
        endcase
    endtask

    task automatic reg_check(input string req, input logic [2:0] sel, input logic [31:0] exp);
        reg_sel = sel; #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic check_state(input string req);
        reg_check(req, 3'd2, 32'(m_rd));
        reg_check(req, 3'd3, 32'(m_pe));
        reg_check(req, 3'd4, {31'd0, m_viol});
        check(req, {31'd0, irq}, {31'd0, m_viol & m_mask});
    endtask

    task automatic access(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit g;
        g = exp_grant(op, a, m_rd, m_pe);
        acc_valid = 1'b1; acc_op = op; acc_addr = a; flash_rdata = d; #1;
        if (op == 2'd0) begin
            check("R2 grant", {31'd0, acc_grant}, {31'd0, g});
            check("R2 rdata", acc_rdata, g ? d : '0);
        end else if (op == 2'd3) begin
            check("R4 mass grant", {31'd0, acc_grant}, {31'd0, g});
        end else begin
            check("R3 grant", {31'd0, acc_grant}, {31'd0, g});
        end
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
        if (!g) m_viol = 1'b1;
        reg_check("R5 sticky", 3'd4, {31'd0, m_viol});
    endtask

    task automatic do_commit(input logic tgt);
        int cnt = 0;
        reg_write(3'd0, {31'd0, tgt});
        reg_write(3'd1, 32'd1);
        reg_sel = 3'd1; #1;
        while (reg_rdata[0] && cnt < 100) begin
            cnt++;
            @(posedge clk); @(negedge clk); #1;
        end
        check("R7 busy cycles", cnt, CC);
        if (tgt) m_pe_nv = m_pe; else m_rd_nv = m_rd;
    endtask

    task automatic por();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_rd = m_rd_nv; m_pe = m_pe_nv;
        m_viol = 1'b0; m_mask = 1'b0; m_sel = 1'b0;
    endtask

    function automatic logic [31:0] clr_bit();
        return ~(32'd1 << ($urandom % NB));
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        m_rd_nv = '1; m_pe_nv = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        nvm_init_n = 1'b1;
        por();

        // R1 reset state
        reg_check("R1 rden", 3'd2, 32'h0000_00ff);
        reg_check("R1 peen", 3'd3, 32'h0000_00ff);
        reg_check("R1 stat", 3'd4, 32'd0);
        reg_check("R1 mask", 3'd5, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R3 read-only region: read allowed, program refused
        reg_write(3'd3, 32'hffff_fffb);
        access(2'd0, 14'(2 << BLK_SHIFT), 32'hdead_beef);
        access(2'd1, 14'(2 << BLK_SHIFT) | 14'h3c, 32'h0);
        access(2'd2, 14'(3 << BLK_SHIFT), 32'h0);
        // R4 mass erase refused with one region protected
        access(2'd3, 14'h0, 32'h0);
        // R5 irq with mask, then W1C
        reg_write(3'd5, 32'd1);
        check_state("R5 irq");
        reg_write(3'd4, 32'd1);
        check_state("R5 w1c");
        // R6 writing ones cannot re-enable
        reg_write(3'd3, 32'hffff_ffff);
        check_state("R6 set ignored");
        // R2 protected read returns zero
        reg_write(3'd2, 32'hffff_ff7f);
        access(2'd0, 14'(7 << BLK_SHIFT) | 14'h7ff, 32'h1234_5678);
        // R7/R8: commit PE only, reset restores uncommitted RD bit
        do_commit(1'b1);
        por();
        check_state("R8 after por");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int k = int'($urandom % 100);
            if (k < 45) begin
                access(2'($urandom % 4), AW'($urandom), $urandom);
            end else if (k < 55) begin
                reg_write(($urandom % 2) ? 3'd2 : 3'd3,
                          ($urandom % 3 == 0) ? 32'hffff_ffff : clr_bit());
            end else if (k < 62) begin
                reg_write(3'd4, 32'd1);
            end else if (k < 68) begin
                reg_write(3'd5, {31'd0, 1'($urandom)});
            end else if (k < 74) begin
                do_commit(1'($urandom));
            end else if (k < 78) begin
                por();
                check_state("R8 random por");
                if ($urandom % 4 == 0) begin
                    // Restore open access occasionally via factory init
                    nvm_init_n = 1'b0;
                    m_rd_nv = '1; m_pe_nv = '1;
                    por();
                    nvm_init_n = 1'b1;
                    por();
                    check_state("R1 refactory");
                end
            end else begin
                check_state("R6 state");
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #1900000;
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule